// File: doc/BRIEF.md
# Trigger-Latency Sample Pipeline with Event Buffers

This block serves one channel of a waveform digitizer. Every clock it takes a 9-bit amplitude sample. At full rate it writes every sample into a circular pipeline. At half rate it writes every second one. Older samples stay in the pipeline long enough for a slower trigger decision to arrive. When a trigger is accepted, the block fixes a start point that lies a programmable number of system clocks back in time. From that start point it copies a window of samples, 8 to 32 long, into the next free event buffer. Triggers that arrive while an earlier window is still being copied wait in order. A trigger that finds every buffer taken is dropped and counted.

A readout port hands the stored records out oldest first, one sample per accepted transfer. It flags the final sample of each record. A buffer is returned to the pool only when that final sample is taken. Independently of capture, the block raises a fast trigger bit for each sample above a programmable threshold. The rate select and the look-back latency are captured only during reset or a flush. A flush also empties the pipeline state and all buffers.

Top module: `evt_pipe_capture`

## Requirements
- R1: In the first clock after reset or flush, and in every clock at full rate (`half_rate` = 0 when captured), a sample is written. At half rate (`half_rate` = 1) only the first clock after reset/flush and every second clock after it write. Written samples are numbered 0, 1, 2, … from reset/flush.
- R2: If n samples have been written before the clock in which `trig_in` is accepted, the record starts with sample n − Ls. Ls is the captured latency at full rate and the captured latency divided by two, rounded down, at half rate. So at full rate with latency 0 the record starts with the sample presented in the trigger clock.
- R3: The record length is `win_len` as sampled in the trigger clock, clamped to 8 when smaller than 8 and to 32 when larger than 32. The samples of a record are consecutive written samples.
- R4: Four event buffers exist. A trigger is accepted when fewer than four records are pending, being captured or awaiting readout. Accepted triggers are captured and delivered in arrival order.
- R5: A trigger that arrives while four records are held is dropped. It increments the 8-bit `ovf_count`, which saturates at 255.
- R6: Readout uses valid/ready. A beat transfers in a clock where `rd_valid` and `rd_ready` are both 1. `rd_data` and `rd_last` hold steady while a beat waits. `rd_last` is 1 only on the final sample of a record. The buffer is freed once that beat transfers.
- R7: `fast_trig` is 1 in the clock after a sample strictly greater than `threshold` was presented, and 0 otherwise (equal is not greater).
- R8: `latency` and `half_rate` are captured only in clocks with `rst` or `flush` high. Changes at other times have no effect on later records.
- R9: A flush discards every record, including one partly captured, and ignores a trigger in the same clock. `rd_valid` is 0 in the next clock. `ovf_count` is kept.
- R10: After reset, `rd_valid`, `fast_trig` and `ovf_count` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clears pipeline, captures and buffers; captures configuration |
| half_rate | input | 1 | Rate select captured on reset/flush: 0 full, 1 half |
| latency | input | 8 | Look-back in system clocks, captured on reset/flush |
| win_len | input | 6 | Record length request, clamped to 8..32 |
| threshold | input | 9 | Fast trigger threshold |
| smp_in | input | 9 | Amplitude sample |
| trig_in | input | 1 | Trigger request |
| fast_trig | output | 1 | Sample-above-threshold flag |
| rd_valid | output | 1 | Readout beat available |
| rd_ready | input | 1 | Readout beat accepted |
| rd_data | output | 9 | Readout sample |
| rd_last | output | 1 | Final sample of the record |
| ovf_count | output | 8 | Saturating count of dropped triggers |

## Verification
Samples follow a position-dependent sequence, so a record taken from the wrong start, with the wrong length or in the wrong order shows as a mismatch. Triggers are tried at full rate with latencies 20, 0 and 200, and at half rate with latencies 255 and 7. This separates the sample-domain conversion, its rounding and the same-clock case. A burst of five triggers against a stalled reader and then a long drop burst probe buffer exhaustion and counter saturation. The buffers are then drained with an irregular ready pattern that exercises holding of the data. Changing the latency without a flush, requesting windows below and above the limits, and flushing during a capture that is still waiting for data separate latched from live configuration, clamping, and discard behaviour.

// File: rtl/evtcap_pkg.sv
package evtcap_pkg;

    localparam int SMP_W   = 9;
    localparam int LAT_W   = 8;
    localparam int MIN_WIN = 8;
    localparam int MAX_WIN = 32;
    localparam int WIN_W   = $clog2(MAX_WIN + 1);
    localparam int IDX_W   = $clog2(MAX_WIN);
    localparam int PIPE_AW = $clog2((1 << LAT_W) + MAX_WIN);

    typedef enum logic {
        CAP_IDLE,
        CAP_COPY
    } cap_state_e;

    typedef struct packed {
        logic [PIPE_AW-1:0] start;
        logic [WIN_W-1:0]   len;
    } trig_rec_t;

    function automatic logic [WIN_W-1:0] clamp_win(input logic [WIN_W-1:0] w);
        if (w < WIN_W'(MIN_WIN)) return WIN_W'(MIN_WIN);
        if (w > WIN_W'(MAX_WIN)) return WIN_W'(MAX_WIN);
        return w;
    endfunction

endpackage

// File: rtl/evtcap_pipeline.sv
module evtcap_pipeline
    import evtcap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               half_cfg,
    input  logic [SMP_W-1:0]   smp_in,
    output logic [PIPE_AW-1:0] wr_ptr,
    input  logic [PIPE_AW-1:0] rd_addr,
    output logic [SMP_W-1:0]   rd_sample
);
    localparam int DEPTH = 1 << PIPE_AW;

    logic [SMP_W-1:0] mem [DEPTH];
    logic             phase;
    logic             wr_en;

    // every clock at full rate; at half rate only on even phase
    assign wr_en = !half_cfg || !phase;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            phase  <= 1'b0;
        end else begin
            phase <= half_cfg ? ~phase : 1'b0;
            if (wr_en) wr_ptr <= wr_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!(rst || flush) && wr_en) mem[wr_ptr] <= smp_in;
    end

    assign rd_sample = mem[rd_addr];

endmodule

// File: rtl/evtcap_engine.sv
module evtcap_engine
    import evtcap_pkg::*;
#(
    parameter int NUM_BUF = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  logic [$clog2(NUM_BUF)-1:0] push_slot,
    input  trig_rec_t                  push_rec,
    input  logic                       pending,
    input  logic [$clog2(NUM_BUF)-1:0] cap_slot,
    input  logic [PIPE_AW-1:0]         wr_ptr,
    output logic [PIPE_AW-1:0]         rd_addr,
    input  logic [SMP_W-1:0]           rd_sample,
    output logic                       buf_we,
    output logic [IDX_W-1:0]           buf_idx,
    output logic [SMP_W-1:0]           buf_data,
    output logic                       done,
    output logic [WIN_W-1:0]           done_len
);
    trig_rec_t          tbl [NUM_BUF];
    cap_state_e         state;
    logic [PIPE_AW-1:0] addr;
    logic [WIN_W-1:0]   cnt;
    logic [WIN_W-1:0]   len;
    logic               avail;

    always_ff @(posedge clk) begin
        if (push) tbl[push_slot] <= push_rec;
    end

    // a sample may be copied only once the pipeline has written it
    assign avail    = (addr != wr_ptr);
    assign rd_addr  = addr;
    assign buf_we   = (state == CAP_COPY) && avail;
    assign buf_idx  = cnt[IDX_W-1:0];
    assign buf_data = rd_sample;
    assign done     = buf_we && (cnt == len - WIN_W'(1));
    assign done_len = len;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            state <= CAP_IDLE;
            addr  <= '0;
            cnt   <= '0;
            len   <= '0;
        end else begin
            case (state)
                CAP_IDLE: begin
                    if (pending) begin
                        addr  <= tbl[cap_slot].start;
                        len   <= tbl[cap_slot].len;
                        cnt   <= '0;
                        state <= CAP_COPY;
                    end
                end
                CAP_COPY: begin
                    if (avail) begin
                        addr <= addr + 1'b1;
                        cnt  <= cnt + 1'b1;
                        if (done) state <= CAP_IDLE;
                    end
                end
                default: state <= CAP_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/evtcap_bufs.sv
module evtcap_bufs
    import evtcap_pkg::*;
#(
    parameter int NUM_BUF = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       wr_en,
    input  logic [$clog2(NUM_BUF)-1:0] wr_slot,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [SMP_W-1:0]           wr_data,
    input  logic                       done,
    input  logic [WIN_W-1:0]           done_len,
    input  logic                       rd_avail,
    input  logic [$clog2(NUM_BUF)-1:0] rd_slot,
    input  logic                       rd_ready,
    output logic                       rd_valid,
    output logic [SMP_W-1:0]           rd_data,
    output logic                       rd_last,
    output logic                       free
);
    localparam int DEPTH = NUM_BUF << IDX_W;

    logic [SMP_W-1:0] mem  [DEPTH];
    logic [WIN_W-1:0] lens [NUM_BUF];
    logic [IDX_W-1:0] ridx;

    always_ff @(posedge clk) begin
        if (wr_en) mem[{wr_slot, wr_idx}] <= wr_data;
        if (done) lens[wr_slot] <= done_len;
    end

    assign rd_valid = rd_avail;
    assign rd_data  = mem[{rd_slot, ridx}];
    assign rd_last  = (WIN_W'(ridx) == lens[rd_slot] - WIN_W'(1));
    assign free     = rd_valid && rd_ready && rd_last;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ridx <= '0;
        end else if (rd_valid && rd_ready) begin
            ridx <= rd_last ? '0 : ridx + 1'b1;
        end
    end

endmodule

// File: rtl/evt_pipe_capture.sv
module evt_pipe_capture
    import evtcap_pkg::*;
#(
    parameter int NUM_BUF = 4,
    parameter int OVF_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             half_rate,
    input  logic [LAT_W-1:0] latency,
    input  logic [WIN_W-1:0] win_len,
    input  logic [SMP_W-1:0] threshold,
    input  logic [SMP_W-1:0] smp_in,
    input  logic             trig_in,
    output logic             fast_trig,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [SMP_W-1:0] rd_data,
    output logic             rd_last,
    output logic [OVF_W-1:0] ovf_count
);
    localparam int SW = $clog2(NUM_BUF);
    localparam int PW = SW + 1;

    logic               cfg_half;
    logic [LAT_W-1:0]   cfg_lat;
    logic [PIPE_AW-1:0] lat_smp;
    logic [PW-1:0]      alloc_p, cap_p, rd_p, used;
    logic               full, accept, pending, rd_avail;
    logic [PIPE_AW-1:0] wr_ptr, pipe_addr;
    logic [SMP_W-1:0]   pipe_sample, buf_data;
    logic               buf_we, done, free;
    logic [IDX_W-1:0]   buf_idx;
    logic [WIN_W-1:0]   done_len;
    trig_rec_t          new_rec;

    // configuration is frozen between reset/flush events
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            cfg_half <= half_rate;
            cfg_lat  <= latency;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) fast_trig <= 1'b0;
        else     fast_trig <= (smp_in > threshold);
    end

    assign lat_smp  = cfg_half ? PIPE_AW'(cfg_lat >> 1) : PIPE_AW'(cfg_lat);
    assign used     = alloc_p - rd_p;
    assign full     = (used == PW'(NUM_BUF));
    assign accept   = trig_in && !full && !flush;
    assign pending  = (alloc_p != cap_p);
    assign rd_avail = (cap_p != rd_p);

    assign new_rec.start = wr_ptr - lat_smp;
    assign new_rec.len   = clamp_win(win_len);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            alloc_p <= '0;
            cap_p   <= '0;
            rd_p    <= '0;
        end else begin
            if (accept) alloc_p <= alloc_p + 1'b1;
            if (done)   cap_p   <= cap_p + 1'b1;
            if (free)   rd_p    <= rd_p + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_count <= '0;
        end else if (trig_in && full && !flush && (ovf_count != '1)) begin
            ovf_count <= ovf_count + 1'b1;
        end
    end

    evtcap_pipeline u_pipe (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .half_cfg  (cfg_half),
        .smp_in    (smp_in),
        .wr_ptr    (wr_ptr),
        .rd_addr   (pipe_addr),
        .rd_sample (pipe_sample)
    );

    evtcap_engine #(.NUM_BUF(NUM_BUF)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push      (accept),
        .push_slot (alloc_p[SW-1:0]),
        .push_rec  (new_rec),
        .pending   (pending),
        .cap_slot  (cap_p[SW-1:0]),
        .wr_ptr    (wr_ptr),
        .rd_addr   (pipe_addr),
        .rd_sample (pipe_sample),
        .buf_we    (buf_we),
        .buf_idx   (buf_idx),
        .buf_data  (buf_data),
        .done      (done),
        .done_len  (done_len)
    );

    evtcap_bufs #(.NUM_BUF(NUM_BUF)) u_bufs (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .wr_en    (buf_we),
        .wr_slot  (cap_p[SW-1:0]),
        .wr_idx   (buf_idx),
        .wr_data  (buf_data),
        .done     (done),
        .done_len (done_len),
        .rd_avail (rd_avail),
        .rd_slot  (rd_p[SW-1:0]),
        .rd_ready (rd_ready),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_last  (rd_last),
        .free     (free)
    );

endmodule

// File: rtl/evtcap_checker.sv
module evtcap_checker #(
    parameter int NUM_BUF = 4,
    parameter int PW      = 3,
    parameter int OVF_W   = 8,
    parameter int SMP_W   = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             flush,
    input logic [SMP_W-1:0] smp_in,
    input logic [SMP_W-1:0] threshold,
    input logic             fast_trig,
    input logic             trig_in,
    input logic             rd_valid,
    input logic             rd_ready,
    input logic [SMP_W-1:0] rd_data,
    input logic             rd_last,
    input logic [OVF_W-1:0] ovf_count,
    input logic [PW-1:0]    used_cnt
);

    assert_fast_hi_R7: assert property (@(posedge clk) disable iff (rst)
        (smp_in > threshold) |=> fast_trig);

    assert_fast_lo_R7: assert property (@(posedge clk) disable iff (rst)
        !(smp_in > threshold) |=> !fast_trig);

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready && !flush) |=> (rd_valid && $stable(rd_data) && $stable(rd_last)));

    assert_flush_empty_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> !rd_valid);

    assert_buf_bound_R4: assert property (@(posedge clk) disable iff (rst)
        used_cnt <= PW'(NUM_BUF));

    assert_ovf_sat_R5: assert property (@(posedge clk) disable iff (rst)
        (ovf_count == '1) |=> (ovf_count == '1));

    assert_ovf_step_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(ovf_count) |-> (ovf_count == $past(ovf_count) + 1'b1));

    assert_ovf_cause_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(ovf_count) |-> ($past(trig_in) && ($past(used_cnt) == PW'(NUM_BUF))));

endmodule

bind evt_pipe_capture evtcap_checker #(
    .NUM_BUF (NUM_BUF),
    .PW      (PW),
    .OVF_W   (OVF_W),
    .SMP_W   (evtcap_pkg::SMP_W)
) u_evtcap_chk (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .smp_in    (smp_in),
    .threshold (threshold),
    .fast_trig (fast_trig),
    .trig_in   (trig_in),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .rd_last   (rd_last),
    .ovf_count (ovf_count),
    .used_cnt  (used)
);

// File: tb/test_evt_pipe_capture.sv
module test_evt_pipe_capture;
    import evtcap_pkg::*;

    localparam int NB = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst, flush, half_rate, trig_in, rd_ready;
    logic             fast_trig, rd_valid, rd_last;
    logic [LAT_W-1:0] latency;
    logic [WIN_W-1:0] win_len;
    logic [SMP_W-1:0] threshold, smp_in, rd_data;
    logic [7:0]       ovf_count;

    int    checks = 0;
    int    errors = 0;
    int    nwr = 0, used_m = 0, ovf_m = 0, lat_m = 20;
    bit    phase_m = 0, half_m = 0;
    string cur_req = "R2";
    logic [SMP_W:0] exp_q [$];

    evt_pipe_capture i_evt_pipe_capture (
        .clk(clk), .rst(rst), .flush(flush), .half_rate(half_rate),
        .latency(latency), .win_len(win_len), .threshold(threshold),
        .smp_in(smp_in), .trig_in(trig_in), .fast_trig(fast_trig),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .rd_last(rd_last), .ovf_count(ovf_count)
    );

    function automatic logic [SMP_W-1:0] patt(input int i);
        return SMP_W'((i * 37 + 11) % 512);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each transferred beat
    always @(negedge clk) begin
        if (!rst && !flush && rd_valid && rd_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, {cur_req, " R6 unexpected beat"}, int'(rd_data), -1);
            end else begin
                logic [SMP_W:0] e;
                e = exp_q.pop_front();
                check(rd_data == e[SMP_W-1:0] && rd_last == e[SMP_W],
                      {cur_req, " R6 record beat"}, int'({rd_last, rd_data}), int'(e));
                if (e[SMP_W]) used_m--;
            end
        end
    end

    // driver: one clock of stimulus plus the expected effect of that clock
    task automatic tick(input bit trig, input bit rdy, input int raw);
        int ls, wl;
        @(posedge clk); #1;
        check(fast_trig == (smp_in > threshold), "R7 fast trigger", int'(fast_trig),
              int'(smp_in > threshold));
        rst = 1'b0; flush = 1'b0;
        rd_ready = rdy; trig_in = trig;
        if (trig) begin
            ls = half_m ? lat_m / 2 : lat_m;
            wl = (win_len < 8) ? 8 : ((win_len > 32) ? 32 : int'(win_len));
            if (used_m < NB) begin
                for (int k = 0; k < wl; k++)
                    exp_q.push_back({(k == wl - 1), patt(nwr - ls + k)});
                used_m++;
            end else if (ovf_m < 255) begin
                ovf_m++;
            end
        end
        if (!half_m || !phase_m) begin
            smp_in = (raw >= 0) ? SMP_W'(raw) : patt(nwr);
            nwr++;
        end else begin
            smp_in = patt(nwr) ^ 9'h0AA;
        end
        phase_m = half_m ? ~phase_m : 1'b0;
    endtask

    task automatic run(input int n, input bit rdy);
        repeat (n) tick(1'b0, rdy, -1);
    endtask

    task automatic do_flush(input bit half, input int lat, input bit trig);
        @(posedge clk); #1;
        flush = 1'b1; half_rate = half; latency = LAT_W'(lat); trig_in = trig;
        exp_q.delete();
        used_m = 0; nwr = 0; phase_m = 1'b0; half_m = half; lat_m = lat;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        rst = 1'b1; flush = 1'b0; half_rate = 1'b0; latency = 8'd20;
        win_len = 6'd10; threshold = 9'd300; smp_in = '0; trig_in = 1'b0; rd_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check(rd_valid == 1'b0, "R10 rd_valid after reset", int'(rd_valid), 0);
        check(ovf_count == 8'd0, "R10 ovf_count after reset", int'(ovf_count), 0);
        check(fast_trig == 1'b0, "R10 fast_trig after reset", int'(fast_trig), 0);

        // R2 full rate, latency 20, window 10
        cur_req = "R2 R3 latency 20";
        run(300, 1'b1); win_len = 6'd10; tick(1'b1, 1'b1, -1); run(50, 1'b1);

        // R8 latency change without flush; R3 clamp above 32
        cur_req = "R8 R3 latched latency, clamp high";
        latency = 8'd100; win_len = 6'd40; tick(1'b1, 1'b1, -1); run(60, 1'b1);

        // R2 latency 0; R3 clamp below 8
        cur_req = "R2 R3 latency 0, clamp low";
        do_flush(1'b0, 0, 1'b0); win_len = 6'd3; run(5, 1'b1);
        tick(1'b1, 1'b1, -1); run(40, 1'b1);

        // R1 half rate, latency 255 -> 127 samples
        cur_req = "R1 R2 half rate latency 255";
        do_flush(1'b1, 255, 1'b0); run(300, 1'b1); win_len = 6'd16;
        tick(1'b1, 1'b1, -1); run(80, 1'b1);

        // R1 half rate, odd latency 7 -> 3 samples
        cur_req = "R1 R2 half rate latency 7";
        do_flush(1'b1, 7, 1'b0); run(20, 1'b1); win_len = 6'd8;
        tick(1'b1, 1'b1, -1); run(40, 1'b1);

        // R4 R5 four records held, fifth trigger dropped
        cur_req = "R4 R6 ordered drain";
        do_flush(1'b0, 200, 1'b0); run(300, 1'b1); win_len = 6'd32;
        repeat (5) tick(1'b1, 1'b0, -1);
        run(200, 1'b0);
        check(ovf_count == 8'd1, "R5 fifth trigger dropped", int'(ovf_count), 1);
        check(rd_valid == 1'b1, "R4 records held while stalled", int'(rd_valid), 1);
        for (int i = 0; i < 400; i++) tick(1'b0, (i % 3) != 0, -1);
        check(exp_q.size() == 0, "R4 all four records delivered", exp_q.size(), 0);

        // R5 saturation
        cur_req = "R5 saturation refill";
        repeat (4) tick(1'b1, 1'b0, -1);
        run(200, 1'b0);
        repeat (260) tick(1'b1, 1'b0, -1);
        check(ovf_count == 8'd255 && ovf_m == 255, "R5 counter saturates", int'(ovf_count), 255);
        run(300, 1'b1);

        // R9 flush during a capture waiting for samples, trigger in flush clock
        cur_req = "R9 flush discard";
        do_flush(1'b0, 0, 1'b0); win_len = 6'd32; run(5, 1'b1);
        tick(1'b1, 1'b1, -1); run(10, 1'b1);
        do_flush(1'b0, 0, 1'b1);
        run(60, 1'b1);
        check(rd_valid == 1'b0, "R9 partial record discarded", int'(rd_valid), 0);
        check(ovf_count == 8'd255, "R9 ovf_count kept", int'(ovf_count), 255);

        // R7 boundary: equal is not above
        cur_req = "R7 boundary";
        tick(1'b0, 1'b1, 300);
        @(posedge clk); #1;
        check(fast_trig == 1'b0, "R7 sample equal to threshold", int'(fast_trig), 0);
        tick(1'b0, 1'b1, 301);
        @(posedge clk); #1;
        check(fast_trig == 1'b1, "R7 sample one above threshold", int'(fast_trig), 1);

        check(exp_q.size() == 0, "R6 no records left outstanding", exp_q.size(), 0);
        finish_run();
    end

endmodule